// File: doc/BRIEF.md
# Compacted State Save Controller

This controller sequences the saving of selectable processor state components into a memory area that uses a compacted layout. A request is a 64-bit mask, supplied as the low 32 bits of two 64-bit source registers. That mask is combined with a 64-bit feature-enable register and a 64-bit in-use bitmap to decide which components are written. The controller computes the two header words for the area and emits one memory write command per saved component, each with an offset relative to the area base and a byte size. It then emits the two header-word writes.

Components 0 and 1 have fixed slots at the bottom of the area. Every component from index 2 upward whose bit is set in the compaction bitmap gets a slot. These slots are packed back to back from offset 576 in ascending index order. A component that is requested but not in use still reserves its slot, although nothing is written to it. Component 1 has one special case: it is also saved when its control/status word is not at its reset value.

A start strobe accepted while idle captures the inputs. A destination that is not 64-byte aligned produces a fault and no writes. Otherwise the controller walks the component indices one per cycle, holds each write command until `wr_ready`, and pulses `done` when it finishes.

Top module: `cstate_save_ctrl`

## Requirements
- R1: The requested bitmap is `{req_hi[31:0], req_lo[31:0]} & feat_en`. Bits 63:32 of `req_hi` and of `req_lo` have no effect on any output.
- R2: `hdr_compmask` equals the requested bitmap with bit 63 forced to 1. Its bits 62:0 equal requested bits 62:0. After reset it reads 64'h8000_0000_0000_0000.
- R3: Component i gets a write command if and only if requested bit i and `in_use[i]` are both 1. Component writes come in ascending index order.
- R4: Component 1 is also written when requested bit 1 is 1 and `ctl_word` differs from 32'h0000_1F80, even if `in_use[1]` is 0. In that case `hdr_present[1]` is 1.
- R5: `hdr_present` equals the requested bitmap AND `in_use`, with bit 1 also set under the R4 rule. Bits clear in the requested bitmap read 0.
- R6: If `dest_addr[5:0]` is not zero, `fault` is 1 and no write command is issued for that request. `done` still pulses. `fault` is cleared by the next accepted aligned start.
- R7: Component 0 is written at offset 0 with size 160. Component 1 is written at offset 160 with size 256. No component write touches bytes 464 to 511.
- R8: Each component i ≥ 2 whose `hdr_compmask` bit is set reserves 64·((i mod 3)+1) bytes. These slots are placed contiguously from offset 576 in ascending index order, and requested-but-unused components also reserve space.
- R9: After all component writes, two header writes follow with `wr_hdr`=1 and size 8. The first goes to offset 512 with data `hdr_present`. The second goes to offset 520 with data `hdr_compmask`.
- R10: While `wr_valid` is 1 and `wr_ready` is 0, the command and its fields hold unchanged on the next cycle.
- R11: `busy` is 1 from the cycle after an accepted start until `done`. `done` is a one-cycle pulse. A start seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a save (accepted only when idle) |
| req_lo | input | 64 | Source register for mask bits 31:0 (low 32 bits used) |
| req_hi | input | 64 | Source register for mask bits 63:32 (low 32 bits used) |
| feat_en | input | 64 | Feature-enable register |
| in_use | input | 64 | In-use bitmap |
| ctl_word | input | 32 | Component-1 control/status word |
| dest_addr | input | 64 | Destination base address |
| wr_ready | input | 1 | Memory side accepts the current command |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Misaligned destination on last accepted start |
| hdr_present | output | 64 | State-present header word |
| hdr_compmask | output | 64 | Compaction header word |
| wr_valid | output | 1 | Write command valid |
| wr_hdr | output | 1 | Command is a header-word write |
| wr_offset | output | 16 | Byte offset from area base |
| wr_size | output | 16 | Byte count |
| wr_data | output | 64 | Header word data (0 for component writes) |

## Verification
The assertions assume that `wr_ready` is a free-running input that may change on any cycle. They also assume the mask inputs matter only in the cycle a start is accepted. The stimulus therefore drives `wr_ready` from a pseudo-random pattern with stalls of varying length. It changes every request input, and pulses a misaligned start, while a save is running. The layout checks rely on the bench never requesting more than the 64 indices the controller walks.

// File: rtl/cstate_pkg.sv
package cstate_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WALK,
      ST_HDR0,
      ST_HDR1,
      ST_FIN
   } save_st_t;

   // Default slot size of an extended component, in bytes.
   function automatic int unsigned ext_size(int unsigned idx, int unsigned unit);
      return unit * ((idx % 3) + 1);
   endfunction

endpackage

// File: rtl/cstate_mask_unit.sv
module cstate_mask_unit #(
   parameter logic [31:0] CTL_INIT = 32'h0000_1F80
) (
   input  logic [63:0] req_lo,
   input  logic [63:0] req_hi,
   input  logic [63:0] feat_en,
   input  logic [63:0] in_use,
   input  logic [31:0] ctl_word,
   output logic [63:0] save_vec,
   output logic [63:0] present,
   output logic [63:0] compmask
);
   logic [63:0] rfbm;
   logic        ctl_dirty;
   logic        unused_upper;

   assign unused_upper = ^{req_lo[63:32], req_hi[63:32]};

   assign rfbm      = {req_hi[31:0], req_lo[31:0]} & feat_en;
   assign ctl_dirty = (ctl_word != CTL_INIT);
   assign save_vec  = (rfbm & in_use) | {62'b0, rfbm[1] & ctl_dirty, 1'b0};
   assign present   = save_vec;
   assign compmask  = {1'b1, rfbm[62:0]};

endmodule

// File: rtl/cstate_size_table.sv
module cstate_size_table #(
   parameter int NCOMP = 64,
   parameter int SZ_W  = 16,
   parameter int UNIT  = 64,
   parameter int IDX_W = $clog2(NCOMP)
) (
   input  logic [IDX_W-1:0] idx,
   output logic [SZ_W-1:0]  size
);
   logic [SZ_W-1:0] tbl [NCOMP];

   generate
      for (genvar g = 0; g < NCOMP; g++) begin : g_ent
         assign tbl[g] = SZ_W'(cstate_pkg::ext_size(g, UNIT));
      end
   endgenerate

   assign size = tbl[idx];

endmodule

// File: rtl/cstate_walker.sv
module cstate_walker #(
   parameter int NCOMP    = 64,
   parameter int OFF_W    = 16,
   parameter int SZ_W     = 16,
   parameter int EXT_BASE = 576,
   parameter int IDX_W    = $clog2(NCOMP)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             adv,
   input  logic             reserve,
   input  logic [SZ_W-1:0]  size_in,
   output logic [IDX_W-1:0] idx,
   output logic [OFF_W-1:0] off,
   output logic             last
);
   localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NCOMP - 1);
   localparam logic [IDX_W-1:0] FIRST_EXT = IDX_W'(2);

   assign last = (idx == LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n || load) begin
         idx <= '0;
         off <= OFF_W'(EXT_BASE);
      end else if (adv) begin
         if (!last)
            idx <= idx + 1'b1;
         if (reserve && idx >= FIRST_EXT)
            off <= off + OFF_W'(size_in);
      end
   end

endmodule

// File: rtl/cstate_save_ctrl.sv
module cstate_save_ctrl #(
   parameter int          NCOMP      = 64,
   parameter int          ADDR_W     = 64,
   parameter int          OFF_W      = 16,
   parameter int          SZ_W       = 16,
   parameter int          SIZE_UNIT  = 64,
   parameter int          ALIGN_LOG2 = 6,
   parameter int          LEG0_SIZE  = 160,
   parameter int          LEG1_OFF   = 160,
   parameter int          LEG1_SIZE  = 256,
   parameter int          LEG_GAP_LO = 464,
   parameter int          HDR_OFF    = 512,
   parameter int          EXT_BASE   = 576,
   parameter logic [31:0] CTL_INIT   = 32'h0000_1F80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [63:0]       req_lo,
   input  logic [63:0]       req_hi,
   input  logic [63:0]       feat_en,
   input  logic [63:0]       in_use,
   input  logic [31:0]       ctl_word,
   input  logic [ADDR_W-1:0] dest_addr,
   input  logic              wr_ready,
   output logic              busy,
   output logic              done,
   output logic              fault,
   output logic [63:0]       hdr_present,
   output logic [63:0]       hdr_compmask,
   output logic              wr_valid,
   output logic              wr_hdr,
   output logic [OFF_W-1:0]  wr_offset,
   output logic [SZ_W-1:0]   wr_size,
   output logic [63:0]       wr_data
);
   import cstate_pkg::*;

   localparam int IDX_W = $clog2(NCOMP);
   localparam logic [OFF_W-1:0] OFF_HDR0 = OFF_W'(HDR_OFF);
   localparam logic [OFF_W-1:0] OFF_HDR1 = OFF_W'(HDR_OFF + 8);
   localparam logic [OFF_W-1:0] OFF_LEG1 = OFF_W'(LEG1_OFF);
   localparam logic [SZ_W-1:0]  SZ_LEG0  = SZ_W'(LEG0_SIZE);
   localparam logic [SZ_W-1:0]  SZ_LEG1  = SZ_W'(LEG1_SIZE);
   localparam logic [SZ_W-1:0]  SZ_WORD  = SZ_W'(8);

   generate
      if (NCOMP < 3 || NCOMP > 64)
         $error("cstate_save_ctrl: NCOMP must lie in 3..64");
      if (LEG0_SIZE > LEG1_OFF || LEG1_OFF + LEG1_SIZE > LEG_GAP_LO)
         $error("cstate_save_ctrl: legacy slots overlap or reach the reserved gap");
      if (HDR_OFF < LEG_GAP_LO + 48 || HDR_OFF + 16 > EXT_BASE)
         $error("cstate_save_ctrl: header placement inconsistent");
      if (ALIGN_LOG2 < 1 || ALIGN_LOG2 >= ADDR_W)
         $error("cstate_save_ctrl: bad alignment");
   endgenerate

   save_st_t          st;
   logic [63:0]       save_w, present_w, compmask_w;
   logic [63:0]       save_r;
   logic              aligned, accept, load, adv, reserve, last, saving;
   logic [IDX_W-1:0]  idx;
   logic [OFF_W-1:0]  ext_off;
   logic [SZ_W-1:0]   ext_sz;
   logic              unused_addr;

   assign unused_addr = ^dest_addr[ADDR_W-1:ALIGN_LOG2];

   cstate_mask_unit #(.CTL_INIT(CTL_INIT)) mask_i (
      .req_lo   (req_lo),
      .req_hi   (req_hi),
      .feat_en  (feat_en),
      .in_use   (in_use),
      .ctl_word (ctl_word),
      .save_vec (save_w),
      .present  (present_w),
      .compmask (compmask_w)
   );

   cstate_size_table #(.NCOMP(NCOMP), .SZ_W(SZ_W), .UNIT(SIZE_UNIT), .IDX_W(IDX_W)) size_i (
      .idx  (idx),
      .size (ext_sz)
   );

   cstate_walker #(.NCOMP(NCOMP), .OFF_W(OFF_W), .SZ_W(SZ_W), .EXT_BASE(EXT_BASE),
                   .IDX_W(IDX_W)) walk_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .adv     (adv),
      .reserve (reserve),
      .size_in (ext_sz),
      .idx     (idx),
      .off     (ext_off),
      .last    (last)
   );

   assign aligned = (dest_addr[ALIGN_LOG2-1:0] == '0);
   assign accept  = (st == ST_IDLE) && start;
   assign load    = accept && aligned;
   assign saving  = save_r[idx];
   assign reserve = hdr_compmask[idx];
   assign adv     = (st == ST_WALK) && (!saving || wr_ready);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st           <= ST_IDLE;
         fault        <= 1'b0;
         save_r       <= '0;
         hdr_present  <= '0;
         hdr_compmask <= 64'h8000_0000_0000_0000;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               save_r       <= save_w;
               hdr_present  <= present_w;
               hdr_compmask <= compmask_w;
               fault        <= !aligned;
               st           <= aligned ? ST_WALK : ST_FIN;
            end
            ST_WALK: if (adv && last) st <= ST_HDR0;
            ST_HDR0: if (wr_ready)    st <= ST_HDR1;
            ST_HDR1: if (wr_ready)    st <= ST_FIN;
            default:                  st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      wr_valid  = 1'b0;
      wr_hdr    = 1'b0;
      wr_offset = '0;
      wr_size   = '0;
      wr_data   = '0;
      case (st)
         ST_WALK: begin
            wr_valid = saving;
            if (idx == '0) begin
               wr_offset = '0;
               wr_size   = SZ_LEG0;
            end else if (idx == IDX_W'(1)) begin
               wr_offset = OFF_LEG1;
               wr_size   = SZ_LEG1;
            end else begin
               wr_offset = ext_off;
               wr_size   = ext_sz;
            end
         end
         ST_HDR0: begin
            wr_valid  = 1'b1;
            wr_hdr    = 1'b1;
            wr_offset = OFF_HDR0;
            wr_size   = SZ_WORD;
            wr_data   = hdr_present;
         end
         ST_HDR1: begin
            wr_valid  = 1'b1;
            wr_hdr    = 1'b1;
            wr_offset = OFF_HDR1;
            wr_size   = SZ_WORD;
            wr_data   = hdr_compmask;
         end
         default: ;
      endcase
   end

   assign busy = (st != ST_IDLE);
   assign done = (st == ST_FIN);

endmodule

// File: rtl/cstate_save_ctrl_chk.sv
module cstate_save_ctrl_chk #(
   parameter int OFF_W      = 16,
   parameter int SZ_W       = 16,
   parameter int LEG_GAP_LO = 464,
   parameter int EXT_BASE   = 576
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_valid,
   input logic             wr_ready,
   input logic             wr_hdr,
   input logic [OFF_W-1:0] wr_offset,
   input logic [SZ_W-1:0]  wr_size,
   input logic             fault,
   input logic             done,
   input logic             busy,
   input logic [63:0]      hdr_present,
   input logic [63:0]      hdr_compmask
);

   assert_hold_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_offset) && $stable(wr_size) && $stable(wr_hdr));

   assert_legacy_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_hdr |->
         (32'(wr_offset) >= EXT_BASE) || (32'(wr_offset) + 32'(wr_size) <= LEG_GAP_LO));

   assert_fault_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !wr_valid);

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);

   assert_bit63_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_compmask[63]);

   assert_present_in_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_present & ~hdr_compmask) == 64'b0);

endmodule

bind cstate_save_ctrl cstate_save_ctrl_chk #(
   .OFF_W(OFF_W), .SZ_W(SZ_W), .LEG_GAP_LO(LEG_GAP_LO), .EXT_BASE(EXT_BASE)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_valid     (wr_valid),
   .wr_ready     (wr_ready),
   .wr_hdr       (wr_hdr),
   .wr_offset    (wr_offset),
   .wr_size      (wr_size),
   .fault        (fault),
   .done         (done),
   .busy         (busy),
   .hdr_present  (hdr_present),
   .hdr_compmask (hdr_compmask)
);

// File: tb/cstate_save_ctrl_tb_top.sv
module cstate_save_ctrl_tb_top;

   typedef struct packed {
      logic        hdr;
      logic [15:0] off;
      logic [15:0] sz;
      logic [63:0] data;
   } wr_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [63:0] req_lo = '0, req_hi = '0, feat_en = '0, in_use = '0, dest_addr = '0;
   logic [31:0] ctl_word = 32'h1F80;
   logic        wr_ready = 1'b0;
   logic        busy, done, fault, wr_valid, wr_hdr;
   logic [63:0] hdr_present, hdr_compmask, wr_data;
   logic [15:0] wr_offset, wr_size;

   int          n_tests = 0;
   int          n_fail  = 0;
   wr_item_t    exp_q[$];
   string       tag_q[$];
   logic [63:0] exp_present, exp_cm;
   logic [15:0] lfsr = 16'hACE1;
   bit          always_ready = 1'b0;

   always #10 clk = ~clk;

   cstate_save_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .req_lo(req_lo), .req_hi(req_hi),
      .feat_en(feat_en), .in_use(in_use), .ctl_word(ctl_word), .dest_addr(dest_addr),
      .wr_ready(wr_ready), .busy(busy), .done(done), .fault(fault),
      .hdr_present(hdr_present), .hdr_compmask(hdr_compmask), .wr_valid(wr_valid),
      .wr_hdr(wr_hdr), .wr_offset(wr_offset), .wr_size(wr_size), .wr_data(wr_data)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Reference model built from the requirements
   task automatic build_expect(input logic [63:0] lo, hi, fen, iu, input logic [31:0] ctl,
                               input bit push);
      logic [63:0] rfbm, sv;
      int unsigned off;
      rfbm = {hi[31:0], lo[31:0]} & fen;                         // R1
      sv   = rfbm & iu;                                          // R3
      if (rfbm[1] && ctl != 32'h0000_1F80) sv[1] = 1'b1;         // R4
      exp_present = sv;                                          // R5
      exp_cm      = rfbm | 64'h8000_0000_0000_0000;              // R2
      if (!push) return;
      if (sv[0]) begin exp_q.push_back('{1'b0, 16'd0, 16'd160, 64'd0}); tag_q.push_back("R7 comp0"); end
      if (sv[1]) begin exp_q.push_back('{1'b0, 16'd160, 16'd256, 64'd0}); tag_q.push_back("R4 R7 comp1"); end
      off = 576;                                                  // R8
      for (int i = 2; i < 64; i++) begin
         if (exp_cm[i]) begin
            if (sv[i]) begin
               exp_q.push_back('{1'b0, 16'(off), 16'(64 * ((i % 3) + 1)), 64'd0});
               tag_q.push_back($sformatf("R3 R8 comp%0d", i));
            end
            off += 64 * ((i % 3) + 1);
         end
      end
      exp_q.push_back('{1'b1, 16'd512, 16'd8, sv});     tag_q.push_back("R9 hdr0");
      exp_q.push_back('{1'b1, 16'd520, 16'd8, exp_cm}); tag_q.push_back("R9 hdr1");
   endtask

   // Ready driver and scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         wr_ready <= always_ready | lfsr[0] | lfsr[3];
         #1;
         if (rst_n && wr_valid && wr_ready) begin
            if (exp_q.size() == 0) begin
               check("R3 R6 unexpected write", {wr_hdr, 15'd0, wr_offset, wr_size}, 64'd0);
               n_fail += (n_fail == 0) ? 1 : 0;
            end else begin
               wr_item_t e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check({t, " kind/offset/size"}, {31'd0, wr_hdr, wr_offset, wr_size},
                     {31'd0, e.hdr, e.off, e.sz});
               check({t, " data"}, wr_data, e.data);
            end
         end
      end
   end

   task automatic run_op(input logic [63:0] lo, hi, fen, iu, input logic [31:0] ctl,
                         input logic [63:0] addr, input bit intrude);
      bit exp_fault;
      exp_fault = (addr[5:0] != 6'd0);
      build_expect(lo, hi, fen, iu, ctl, !exp_fault);
      @(negedge clk);
      req_lo = lo; req_hi = hi; feat_en = fen; in_use = iu; ctl_word = ctl; dest_addr = addr;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R11 busy after start", {63'd0, busy}, 64'd1);
      if (intrude) begin
         repeat (5) @(negedge clk);
         req_lo = ~lo; req_hi = '0; feat_en = '0; in_use = '0; ctl_word = 32'h0;
         dest_addr = addr + 64'd3;
         start = 1'b1;                                           // R11 ignored while busy
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
      check("R6 fault", {63'd0, fault}, {63'd0, exp_fault});
      check("R5 hdr_present", hdr_present, exp_present);
      check("R2 R1 hdr_compmask", hdr_compmask, exp_cm);
      check("R3 R9 all writes seen", 64'(exp_q.size()), 64'd0);
      exp_q.delete();
      tag_q.delete();
      @(negedge clk);
      check("R11 done is one cycle", {62'd0, done, busy}, 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 reset busy/done/fault/valid", {60'd0, busy, done, fault, wr_valid}, 64'd0);
      check("R2 reset compmask", hdr_compmask, 64'h8000_0000_0000_0000);
      check("R5 reset present", hdr_present, 64'd0);

      // R1 upper halves of the sources are junk; everything requested and in use
      run_op(64'hDEAD_BEEF_FFFF_FFFF, 64'h1234_5678_FFFF_FFFF, '1, '1, 32'h1F80, 64'h1000, 1'b0);
      // R1 feature-enable masks requests; R8 requested-but-unused reserves space
      run_op(64'h0000_0000_0F0F_00FF, 64'hFFFF_FFFF_8000_0001, 64'h7FFF_FFFF_FFFF_FF3F,
             64'h0000_0001_0A05_0041, 32'h1F80, 64'h2040, 1'b0);
      // R4 component 1 not in use, control word at reset value: not saved
      run_op(64'h0000_0000_0000_0007, 64'd0, '1, 64'h5, 32'h0000_1F80, 64'h80, 1'b0);
      // R4 component 1 not in use, control word changed: saved
      run_op(64'h0000_0000_0000_0007, 64'd0, '1, 64'h5, 32'h0000_1F81, 64'h80, 1'b0);
      // R4 control word changed but component 1 not requested
      run_op(64'h0000_0000_0000_0005, 64'd0, '1, 64'h5, 32'h0001_0000, 64'h80, 1'b0);
      // R6 misaligned destinations
      run_op('1, '1, '1, '1, 32'h1F80, 64'h1001, 1'b0);
      run_op('1, '1, '1, '1, 32'h1F80, 64'h0020, 1'b0);
      // R6 fault cleared by aligned start; empty request gives headers only
      run_op(64'd0, 64'd0, '1, '1, 32'h1F80, 64'h40, 1'b0);
      // R11 start while busy is ignored
      run_op(64'h0000_0000_F0F0_F0F3, 64'h0000_0000_8421_8421, '1, 64'hFFFF_0000_FFFF_0003,
             32'h1F80, 64'h4000, 1'b1);
      // R10 with ready always high, bit 63 requested
      always_ready = 1'b1;
      run_op(64'h0000_0000_AAAA_AAAA, 64'h0000_0000_C000_0000, '1, '1, 32'h1F80, 64'hC0, 1'b0);
      always_ready = 1'b0;

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule